// File: doc/BRIEF.md
# Indirect Clock Channel Configuration Bank

This block keeps the clock routing settings of up to 64 consumer channels behind one 16-bit control word. Each channel entry holds three fields: which generator feeds it, whether its clock runs, and a write lock. Software addresses an entry by its channel number, carried in the low byte of the word. A write strobed as byte-only changes just the selection, and the word read back afterwards describes the selected entry. A full-word write sets the selection and, in the same write, updates that entry.

Changes cross into the clock domain through a short synchronizer, modelled here as a counter of `SYNC_CYC` cycles. A status flag is high during that window, and writes that arrive while it is high are dropped. A cleared enable keeps reading 1 until the window has closed. A global soft reset returns every unlocked entry to its defaults. Locks are sticky: once set, only the power-on reset clears them. The block drives a per-channel enable vector and a flattened generator-select vector for the clock multiplexers that sit outside it.

Top module: `clk_chan_bank`

## Requirements
- R1: While `por_n` is low, and after it is released, every entry holds generator 0, enable 0 and lock 0. The selection is 0, `sync_busy` is 0 and all outputs read 0.
- R2: A write with `wr_byte` high copies `wdata[7:0]` into the selection and ignores `wdata[15:8]`. No entry changes. `rdata` then shows the selected entry as follows: channel number in [7:0], generator zero-extended in [13:8], enable in [14], lock in [15].
- R3: A full-word write (`wr_byte` low) to an unlocked, in-range channel loads the generator from `wdata[8 +: GEN_W]`, the lock from `wdata[15]` and the enable request from `wdata[14]`. It also selects that channel. `ch_gen` and `ch_lock`-driven behaviour follow from the next cycle.
- R4: A full-word write to a locked entry changes nothing in that entry and does not raise `sync_busy`. It still updates the selection.
- R5: A lock bit survives the soft reset. Only `por_n` clears it.
- R6: Writing 1 to `glob_wdata[0]` with `glob_wr` starts a soft reset, and `glob_rdata[0]` reads 1 for `SYNC_CYC` cycles. At the end, every unlocked entry returns to generator 0 and enable 0, and the selection returns to 0. A soft reset takes priority over a control-word write in the same cycle.
- R7: Setting an enable takes effect in the cycle after the write. Clearing an enable leaves the bit reading 1 (on both `ch_en` and `rdata[14]`) for `SYNC_CYC` cycles after the write, after which it reads 0.
- R8: After an accepted full-word write or soft-reset start, `sync_busy` is high for exactly `SYNC_CYC` cycles. Any write or soft-reset request that arrives while it is high is dropped, selection included.
- R9: A full-word write to a channel number at or above `NUM_CH` changes no entry and leaves `sync_busy` low. While such a number is selected, `rdata` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Control-word write strobe |
| wr_byte | input | 1 | 1: low-byte-only write (select); 0: full-word write |
| wdata | input | 16 | Control-word write data |
| rdata | output | 16 | Control word of the selected entry |
| glob_wr | input | 1 | Global control write strobe |
| glob_wdata | input | 8 | Global control data, bit 0 requests soft reset |
| glob_rdata | output | 8 | Global control readback, bit 0 high while soft reset runs |
| ch_en | output | NUM_CH | Per-channel clock enable |
| ch_gen | output | NUM_CH*GEN_W | Per-channel generator select, channel i at [i*GEN_W +: GEN_W] |
| sync_busy | output | 1 | Synchronization in progress |

## Verification
The bench goes after the disable window. A design that clears the enable at once would show `ch_en` low one or two cycles early, and one that never clears it would leave the channel running. A second write issued back-to-back while busy must leave no trace, so a bank that accepts it would show the wrong selection or a modified entry. Locked entries are written after a soft reset and again after a power-on reset: a lock lost to the soft reset, or kept past power-on, shows up directly in the read word. Channel numbers 64 to 255 are both written and selected, so an index that wraps onto a real entry would corrupt it or return non-zero read data.

// File: rtl/clk_chan_bank_pkg.sv
package clk_chan_bank_pkg;
  localparam int WORD_W    = 16;
  localparam int ID_W      = 8;
  localparam int GEN_FLD_W = 6;
  localparam int GEN_LSB   = 8;
  localparam int EN_BIT    = 14;
  localparam int LOCK_BIT  = 15;

  // Assemble the readback word from one entry's fields.
  function automatic logic [WORD_W-1:0] pack_word(input logic [ID_W-1:0] id,
                                                   input logic [GEN_FLD_W-1:0] gen,
                                                   input logic en,
                                                   input logic lock);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ID_W-1:0] = id;
    w[GEN_LSB +: GEN_FLD_W] = gen;
    w[EN_BIT] = en;
    w[LOCK_BIT] = lock;
    return w;
  endfunction

  function automatic logic [ID_W-1:0] word_id(input logic [WORD_W-1:0] w);
    return w[ID_W-1:0];
  endfunction

  function automatic logic word_en(input logic [WORD_W-1:0] w);
    return w[EN_BIT];
  endfunction

  function automatic logic word_lock(input logic [WORD_W-1:0] w);
    return w[LOCK_BIT];
  endfunction
endpackage

// File: rtl/chan_bank_entry.sv
module chan_bank_entry #(
  parameter int GEN_W = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_hit,
  input  logic [GEN_W-1:0] wr_gen,
  input  logic             wr_on,
  input  logic             wr_lock,
  input  logic             off_done,
  input  logic             swrst_done,
  output logic [GEN_W-1:0] gen_q,
  output logic             en_q,
  output logic             lock_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      gen_q  <= '0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_hit) begin
      gen_q  <= wr_gen;
      lock_q <= wr_lock;
      if (wr_on) en_q <= 1'b1;
    end else if (off_done) begin
      en_q <= 1'b0;
    end else if (swrst_done && !lock_q) begin
      gen_q <= '0;
      en_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_bank_seq.sv
module chan_bank_seq #(
  parameter int SYNC_CYC = 2,
  parameter int ID_W     = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            start_wr,
  input  logic            start_off,
  input  logic            start_swrst,
  input  logic [ID_W-1:0] wr_id,
  output logic            busy,
  output logic            swrst_act,
  output logic            off_done,
  output logic [ID_W-1:0] off_id,
  output logic            swrst_done
);
  localparam int CNT_W = $clog2(SYNC_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             op_swrst_q;
  logic             op_off_q;
  logic             last_cyc;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q      <= '0;
      op_swrst_q <= 1'b0;
      op_off_q   <= 1'b0;
      off_id     <= '0;
    end else if (start_swrst) begin
      cnt_q      <= CNT_W'(SYNC_CYC);
      op_swrst_q <= 1'b1;
      op_off_q   <= 1'b0;
    end else if (start_wr) begin
      cnt_q      <= CNT_W'(SYNC_CYC);
      op_swrst_q <= 1'b0;
      op_off_q   <= start_off;
      off_id     <= wr_id;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_cyc   = (cnt_q == CNT_W'(1));
  assign busy       = (cnt_q != '0);
  assign swrst_act  = busy && op_swrst_q;
  assign off_done   = last_cyc && op_off_q && !op_swrst_q;
  assign swrst_done = last_cyc && op_swrst_q;
endmodule

// File: rtl/chan_bank_rd.sv
module chan_bank_rd
  import clk_chan_bank_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int GEN_W  = 4
) (
  input  logic [ID_W-1:0]         sel,
  input  logic [NUM_CH*GEN_W-1:0] gen_flat,
  input  logic [NUM_CH-1:0]       en_vec,
  input  logic [NUM_CH-1:0]       lock_vec,
  output logic [WORD_W-1:0]       rdata
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic             in_range;
  logic [IDX_W-1:0] idx;

  assign in_range = (int'(sel) < NUM_CH);
  assign idx      = sel[IDX_W-1:0];

  always_comb begin
    if (in_range)
      rdata = pack_word(sel, GEN_FLD_W'(gen_flat[idx*GEN_W +: GEN_W]),
                        en_vec[idx], lock_vec[idx]);
    else
      rdata = '0;
  end
endmodule

// File: rtl/clk_chan_bank.sv
module clk_chan_bank
  import clk_chan_bank_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int GEN_W    = 4,
  parameter int SYNC_CYC = 2
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    wr_en,
  input  logic                    wr_byte,
  input  logic [15:0]             wdata,
  output logic [15:0]             rdata,
  input  logic                    glob_wr,
  input  logic [7:0]              glob_wdata,
  output logic [7:0]              glob_rdata,
  output logic [NUM_CH-1:0]       ch_en,
  output logic [NUM_CH*GEN_W-1:0] ch_gen,
  output logic                    sync_busy
);
  localparam int IDX_W = $clog2(NUM_CH);

  logic [ID_W-1:0]   sel_q;
  logic [NUM_CH-1:0] lock_vec;
  logic              sw_go;
  logic              wr_acc;
  logic [ID_W-1:0]   id_in;
  logic [IDX_W-1:0]  id_idx;
  logic              id_ok;
  logic              full_go;
  logic              swrst_act;
  logic              off_done;
  logic [ID_W-1:0]   off_id;
  logic              swrst_done;

  // Request qualification: nothing is accepted while a sync window is open.
  assign sw_go   = glob_wr && glob_wdata[0] && !sync_busy;
  assign wr_acc  = wr_en && !sync_busy && !sw_go;
  assign id_in   = word_id(wdata);
  assign id_idx  = id_in[IDX_W-1:0];
  assign id_ok   = (int'(id_in) < NUM_CH);
  assign full_go = wr_acc && !wr_byte && id_ok && !lock_vec[id_idx];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          sel_q <= '0;
    else if (swrst_done) sel_q <= '0;
    else if (wr_acc)     sel_q <= id_in;
  end

  chan_bank_seq #(.SYNC_CYC(SYNC_CYC), .ID_W(ID_W)) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .start_wr   (full_go),
    .start_off  (!word_en(wdata)),
    .start_swrst(sw_go),
    .wr_id      (id_in),
    .busy       (sync_busy),
    .swrst_act  (swrst_act),
    .off_done   (off_done),
    .off_id     (off_id),
    .swrst_done (swrst_done)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ent
    logic hit_i;
    logic off_i;
    assign hit_i = full_go && (id_idx == IDX_W'(i));
    assign off_i = off_done && (int'(off_id) == i);
    chan_bank_entry #(.GEN_W(GEN_W)) u_ent (
      .clk       (clk),
      .por_n     (por_n),
      .wr_hit    (hit_i),
      .wr_gen    (wdata[GEN_LSB +: GEN_W]),
      .wr_on     (word_en(wdata)),
      .wr_lock   (word_lock(wdata)),
      .off_done  (off_i),
      .swrst_done(swrst_done),
      .gen_q     (ch_gen[i*GEN_W +: GEN_W]),
      .en_q      (ch_en[i]),
      .lock_q    (lock_vec[i])
    );
  end

  chan_bank_rd #(.NUM_CH(NUM_CH), .GEN_W(GEN_W)) u_rd (
    .sel     (sel_q),
    .gen_flat(ch_gen),
    .en_vec  (ch_en),
    .lock_vec(lock_vec),
    .rdata   (rdata)
  );

  assign glob_rdata = {7'b0, swrst_act};
endmodule

// File: rtl/chan_bank_chk.sv
module chan_bank_chk #(
  parameter int NUM_CH = 64,
  parameter int GEN_W  = 4
) (
  input logic                    clk,
  input logic                    por_n,
  input logic                    sync_busy,
  input logic [NUM_CH-1:0]       ch_en,
  input logic [NUM_CH*GEN_W-1:0] ch_gen,
  input logic [NUM_CH-1:0]       lock_vec,
  input logic                    full_go,
  input logic [7:0]              sel_q,
  input logic [15:0]             rdata,
  input logic [7:0]              glob_rdata
);
  logic [NUM_CH-1:0]       lock_d;
  logic [NUM_CH-1:0]       en_d;
  logic [NUM_CH*GEN_W-1:0] gen_d;
  logic                    busy_d;
  logic [NUM_CH*GEN_W-1:0] lock_gmask;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_d <= '0;
      en_d   <= '0;
      gen_d  <= '0;
      busy_d <= 1'b0;
    end else begin
      lock_d <= lock_vec;
      en_d   <= ch_en;
      gen_d  <= ch_gen;
      busy_d <= sync_busy;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
    assign lock_gmask[i*GEN_W +: GEN_W] = {GEN_W{lock_d[i]}};
  end

  // R5: a lock never drops without power-on reset
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
    (lock_d & ~lock_vec) == '0);

  // R4: generator of a locked entry never changes
  p_locked_gen_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    ((ch_gen ^ gen_d) & lock_gmask) == '0);

  // R8: no entry update is accepted while busy
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!por_n)
    sync_busy |-> !full_go);

  // R7: an enable only falls at the close of a sync window
  p_en_fall_busy_r7: assert property (@(posedge clk) disable iff (!por_n)
    (|(en_d & ~ch_en)) |-> busy_d);

  // R6: when soft reset finishes, unlocked channels are stopped
  p_swrst_clears_r6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(glob_rdata[0]) |-> ((ch_en & ~lock_vec) == '0));

  // R9: out-of-range selection reads zero
  p_oor_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    (int'(sel_q) >= NUM_CH) |-> (rdata == '0));
endmodule

bind clk_chan_bank chan_bank_chk #(.NUM_CH(NUM_CH), .GEN_W(GEN_W)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sync_busy (sync_busy),
  .ch_en     (ch_en),
  .ch_gen    (ch_gen),
  .lock_vec  (lock_vec),
  .full_go   (full_go),
  .sel_q     (sel_q),
  .rdata     (rdata),
  .glob_rdata(glob_rdata)
);

// File: tb/clk_chan_bank_tb.sv
module clk_chan_bank_tb;
  localparam int NCH = 64;
  localparam int GW  = 4;
  localparam int SC  = 2;

  logic              clk = 1'b0;
  logic              por_n;
  logic              wr_en, wr_byte, glob_wr;
  logic [15:0]       wdata, rdata;
  logic [7:0]        glob_wdata, glob_rdata;
  logic [NCH-1:0]    ch_en;
  logic [NCH*GW-1:0] ch_gen;
  logic              sync_busy;

  always #2 clk = ~clk;

  clk_chan_bank #(.NUM_CH(NCH), .GEN_W(GW), .SYNC_CYC(SC)) u_dut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_byte(wr_byte), .wdata(wdata),
    .rdata(rdata), .glob_wr(glob_wr), .glob_wdata(glob_wdata),
    .glob_rdata(glob_rdata), .ch_en(ch_en), .ch_gen(ch_gen), .sync_busy(sync_busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [GW-1:0] m_gen  [NCH];
  logic          m_en   [NCH];
  logic          m_lock [NCH];
  logic [7:0]    m_sel;

  function automatic logic [15:0] exp_word(input logic [7:0] id);
    logic [15:0] w;
    if (id >= NCH) return 16'h0;
    w = {8'h00, id};
    w[15] = m_lock[id];
    w[14] = m_en[id];
    w[13:8] = {2'b00, m_gen[id]};
    return w;
  endfunction

  function automatic logic [NCH-1:0] exp_en();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = m_en[i];
    return v;
  endfunction

  function automatic logic [NCH*GW-1:0] exp_gen();
    logic [NCH*GW-1:0] v;
    for (int i = 0; i < NCH; i++) v[i*GW +: GW] = m_gen[i];
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NCH; i++) begin
      m_gen[i] = '0; m_en[i] = 1'b0; m_lock[i] = 1'b0;
    end
    m_sel = 8'h0;
  endtask

  function automatic logic [15:0] mk_word(input logic [7:0] id, input logic [GW-1:0] g,
                                          input logic e, input logic l);
    return {l, e, 2'b00, g, id};
  endfunction

  task automatic full_wr(input logic [7:0] id, input logic [GW-1:0] g,
                         input logic e, input logic l);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b0; wdata = mk_word(id, g, e, l);
    @(negedge clk);
    wr_en = 1'b0;
    m_sel = id;
    if (id < NCH && !m_lock[id]) begin
      m_gen[id] = g; m_en[id] = e; m_lock[id] = l;
    end
    repeat (SC) @(negedge clk);
  endtask

  task automatic sel_wr(input logic [7:0] id);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b1; wdata = {8'($urandom), id};
    @(negedge clk);
    wr_en = 1'b0;
    m_sel = id;
  endtask

  task automatic soft_reset();
    @(negedge clk);
    glob_wr = 1'b1; glob_wdata = 8'h01;
    @(negedge clk);
    glob_wr = 1'b0; glob_wdata = 8'h00;
    check("R6", "swrst bit first cycle", 256'(glob_rdata[0]), 256'(1));
    @(negedge clk);
    check("R6", "swrst bit second cycle", 256'(glob_rdata[0]), 256'(1));
    @(negedge clk);
    check("R6", "swrst bit after done", 256'(glob_rdata[0]), 256'(0));
    for (int i = 0; i < NCH; i++)
      if (!m_lock[i]) begin m_gen[i] = '0; m_en[i] = 1'b0; end
    m_sel = 8'h0;
  endtask

  task automatic check_read(input string req);
    check(req, "rdata", 256'(rdata), 256'(exp_word(m_sel)));
  endtask

  task automatic check_outs(input string req);
    check(req, "ch_en", 256'(ch_en), 256'(exp_en()));
    check(req, "ch_gen", 256'(ch_gen), 256'(exp_gen()));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    por_n = 1'b0; wr_en = 1'b0; wr_byte = 1'b0; wdata = '0;
    glob_wr = 1'b0; glob_wdata = '0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1", "ch_en in reset", 256'(ch_en), 256'(0));
    por_n = 1'b1;
    @(negedge clk);
    check("R1", "rdata after reset", 256'(rdata), 256'(0));
    check("R1", "busy after reset", 256'(sync_busy), 256'(0));
    check_outs("R1");

    // R3: basic full write
    full_wr(8'd3, 4'h9, 1'b1, 1'b0);
    check_read("R3");
    check_outs("R3");

    // R2: byte select leaves entries alone
    sel_wr(8'd10);
    check_read("R2");
    sel_wr(8'd3);
    check_read("R2");
    check_outs("R2");

    // R7: disable window, enable immediate
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b0; wdata = mk_word(8'd3, 4'h9, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", "busy cycle 1", 256'(sync_busy), 256'(1));
    check("R7", "rdata en held 1", 256'(rdata[14]), 256'(1));
    check("R7", "ch_en held 1", 256'(ch_en[3]), 256'(1));
    @(negedge clk);
    check("R8", "busy cycle 2", 256'(sync_busy), 256'(1));
    check("R7", "ch_en held 2", 256'(ch_en[3]), 256'(1));
    @(negedge clk);
    check("R8", "busy released", 256'(sync_busy), 256'(0));
    check("R7", "ch_en cleared", 256'(ch_en[3]), 256'(0));
    check("R7", "rdata en cleared", 256'(rdata[14]), 256'(0));
    m_en[3] = 1'b0; m_sel = 8'd3;
    @(negedge clk);
    wr_en = 1'b1; wdata = mk_word(8'd4, 4'h1, 1'b1, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R7", "enable next cycle", 256'(ch_en[4]), 256'(1));
    m_gen[4] = 4'h1; m_en[4] = 1'b1; m_sel = 8'd4;
    repeat (SC) @(negedge clk);

    // R8: back-to-back write dropped
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b0; wdata = mk_word(8'd6, 4'h2, 1'b1, 1'b0);
    @(negedge clk);
    wdata = mk_word(8'd7, 4'h5, 1'b1, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    m_gen[6] = 4'h2; m_en[6] = 1'b1; m_sel = 8'd6;
    @(negedge clk);
    check_read("R8");
    check_outs("R8");

    // R4: locked entry ignores writes
    full_wr(8'd12, 4'h2, 1'b1, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_byte = 1'b0; wdata = mk_word(8'd12, 4'h7, 1'b0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R4", "no busy on locked write", 256'(sync_busy), 256'(0));
    m_sel = 8'd12;
    check_read("R4");
    repeat (SC) @(negedge clk);
    check_outs("R4");

    // R9: out-of-range channel
    full_wr(8'd70, 4'h3, 1'b1, 1'b0);
    check_read("R9");
    check_outs("R9");
    sel_wr(8'd200);
    check_read("R9");

    // R6 / R5: soft reset keeps locks
    soft_reset();
    check_outs("R6");
    check_read("R6");
    sel_wr(8'd12);
    check_read("R5");

    // R1: power-on reset clears locks
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    model_clear();
    sel_wr(8'd12);
    check_read("R1");
    check_outs("R1");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom % 64);
      if (r < 2) begin
        soft_reset();
        check_outs("R6");
      end else if (r < 14) begin
        sel_wr(8'($urandom % 80));
        check_read("R2");
      end else begin
        full_wr(8'($urandom % 80), 4'($urandom), 1'($urandom),
                ($urandom % 24) == 0);
        check_read("R3");
      end
      if (n % 8 == 0) check_outs("R3");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule